// File: doc/BRIEF.md
# Linear Flash Card Memory Select Decoder

This block is the combinational select logic of a 16-bit linear flash memory card. It takes the host slot's control lines (two active-low byte enables, read and write strobes, an attribute-space select, an active-high card reset and the upper address bits) and turns them into per-device chip enables for a bank of byte-wide flash parts arranged as even/odd pairs. It also produces a chip enable for an optional byte-wide attribute memory, shared read and write strobes for the memory parts, and drive enables for the low and high byte lanes of the host data bus.

The low byte enable always maps to the even device and the low lane; the high byte enable always maps to the odd device and the high lane. The block never routes the odd byte onto the low lane, and address bit 0 does not reach it at all. The card density is a parameter that fixes how many flash pairs are populated and which address bits choose among them. Address bits above the density boundary take no part in the decode, so accesses wrap. The per-device ready flags are merged into one card ready output, and the fixed status pins (wait, write protect, two battery-detect lines) are driven to constant levels.

Top module: `pcc_mem_decoder`

## Requirements
- R1: With both byte enables high (standby), every flash chip enable and the attribute chip enable are high, both strobes stay high, and neither lane is driven.
- R2: In common space (attr_sel_n high), byte_en_lo_n low enables the even device (index 2p) of the selected pair p, and byte_en_hi_n low enables the odd device (index 2p+1). On a read, lane_lo_drv follows the low enable and lane_hi_drv follows the high enable. A high-only access drives the high lane and never the low lane.
- R3: A read is rd_n low with wr_n high, and a write is wr_n low with rd_n high. mem_oe_n goes low only for a read and mem_we_n only for a write, and only while at least one device is enabled. With both strobes low or both high, neither goes low and no lane is driven.
- R4: With attr_sel_n low, all flash chip enables are high, and attr_ce_n is low exactly when byte_en_lo_n is low. A read drives only the low lane. A high-only attribute access enables no device, asserts no strobe and drives no lane.
- R5: The pair index is taken from addr_hi, where bit 0 is address bit 21. For 2 MB it is always 0. For 4 MB it is bit 0. For 8 MB it is bits 1:0. For 16 MB it is bits 2:1. All other addr_hi bits are ignored.
- R6: Chip enables of pairs not populated at the configured density (4 MB: indices 7:4; 2 MB: indices 7:2) are always high.
- R7: card_ready is high exactly when all eight dev_ready inputs are high.
- R8: wait_n is constant 1, wr_protect is constant 0, and batt_ok1 and batt_ok2 are constant 1.
- R9: While rst is high, mem_pwr_dn_n is low, all chip enables are high, both strobes are high and no lane is driven. mem_pwr_dn_n is high when rst is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst | input | 1 | Card reset, active high; powers down the flash array |
| byte_en_lo_n | input | 1 | Low (even) byte enable, active low |
| byte_en_hi_n | input | 1 | High (odd) byte enable, active low |
| rd_n | input | 1 | Host read strobe, active low |
| wr_n | input | 1 | Host write strobe, active low |
| attr_sel_n | input | 1 | Attribute space select, active low |
| addr_hi | input | 3 | Address bits 23:21 (bit 0 = A21) |
| dev_ready | input | 8 | Per-device ready flags, high = ready |
| flash_ce_n | output | 8 | Flash chip enables, active low, even index = low byte |
| attr_ce_n | output | 1 | Attribute memory chip enable, active low |
| mem_oe_n | output | 1 | Shared read strobe to memory parts, active low |
| mem_we_n | output | 1 | Shared write strobe to memory parts, active low |
| mem_pwr_dn_n | output | 1 | Flash power-down, active low |
| lane_lo_drv | output | 1 | Card drives data bits 7:0 |
| lane_hi_drv | output | 1 | Card drives data bits 15:8 |
| card_ready | output | 1 | Merged ready/busy, high = all ready |
| wait_n | output | 1 | Wait request, held inactive high |
| wr_protect | output | 1 | Write-protect status, held low |
| batt_ok1 | output | 1 | Battery detect 1, held high |
| batt_ok2 | output | 1 | Battery detect 2, held high |

## Verification
The bench builds three copies of the decoder side by side, at 8 MB, 16 MB and 2 MB. Each copy receives the same full sweep of 512 combinations of reset, both byte enables, both strobes, attribute select and the three upper address bits. Together the copies reach every pair-select mapping: the two-bit select from the low bits, the shifted select that ignores address bit 21, and the degenerate single-pair case whose unpopulated enables must stay high. A separate sweep of all 256 ready patterns covers the merge.

// File: rtl/pcc_pkg.sv
package pcc_pkg;

  // Number of populated even/odd pairs for a density in megabytes.
  function automatic int pairs_for(input int density_mb);
    case (density_mb)
      2:       return 1;
      4:       return 2;
      default: return 4;
    endcase
  endfunction

  // Position of the lowest pair-select bit within addr_hi (bit 0 = A21).
  // Larger parts double the span of each pair, pushing the select up.
  function automatic int pair_offset(input int density_mb);
    return (density_mb == 16) ? 1 : 0;
  endfunction

  // Decoded access intent from the host strobes.
  typedef struct packed {
    logic rd;
    logic wr;
  } access_t;

endpackage

// File: rtl/pcc_access_decode.sv
module pcc_access_decode
  import pcc_pkg::*;
(
  input  logic    rst,
  input  logic    byte_en_lo_n,
  input  logic    byte_en_hi_n,
  input  logic    rd_n,
  input  logic    wr_n,
  input  logic    attr_sel_n,
  output logic    flash_lo_act,
  output logic    flash_hi_act,
  output logic    attr_act,
  output access_t acc,
  output logic    lane_lo,
  output logic    lane_hi
);

  logic live;
  logic any_dev;

  always_comb begin
    live         = ~rst;
    // A read needs the write strobe idle and vice versa.
    acc.rd       = ~rd_n & wr_n;
    acc.wr       = ~wr_n & rd_n;
    // Common space: each byte enable owns its device.
    flash_lo_act = live & attr_sel_n & ~byte_en_lo_n;
    flash_hi_act = live & attr_sel_n & ~byte_en_hi_n;
    // Attribute space holds only even bytes.
    attr_act     = live & ~attr_sel_n & ~byte_en_lo_n;
    any_dev      = flash_lo_act | flash_hi_act | attr_act;
    // Lanes are never crossed: low lane only from the low enable.
    lane_lo      = acc.rd & (flash_lo_act | attr_act);
    lane_hi      = acc.rd & flash_hi_act;
    if (!any_dev) begin
      acc.rd = 1'b0;
      acc.wr = 1'b0;
    end
  end

endmodule

// File: rtl/pcc_pair_select.sv
module pcc_pair_select
  import pcc_pkg::*;
#(
  parameter int DENSITY_MB = 8,
  parameter int MAX_PAIRS  = 4,
  parameter int ADDR_HI_W  = 3
) (
  input  logic [ADDR_HI_W-1:0]   addr_hi,
  input  logic                   lo_act,
  input  logic                   hi_act,
  output logic [2*MAX_PAIRS-1:0] ce_n
);

  localparam int PAIRS    = pairs_for(DENSITY_MB);
  localparam int OFS      = pair_offset(DENSITY_MB);
  localparam int SEL_MASK = PAIRS - 1;

  logic [ADDR_HI_W-1:0] shifted;
  logic [ADDR_HI_W-1:0] pair_idx;

  // Bits above the density's top address drop out through the mask.
  always_comb begin
    shifted  = addr_hi >> OFS;
    pair_idx = shifted & ADDR_HI_W'(SEL_MASK);
  end

  for (genvar p = 0; p < MAX_PAIRS; p++) begin : g_pair
    if (p < PAIRS) begin : g_pop
      logic hit;
      always_comb begin
        hit             = (pair_idx == ADDR_HI_W'(p));
        ce_n[2*p]       = ~(hit & lo_act);
        ce_n[2*p+1]     = ~(hit & hi_act);
      end
    end else begin : g_empty
      always_comb begin
        ce_n[2*p]   = 1'b1;
        ce_n[2*p+1] = 1'b1;
      end
    end
  end

endmodule

// File: rtl/pcc_ready_merge.sv
module pcc_ready_merge #(
  parameter int NUM_DEV = 8
) (
  input  logic [NUM_DEV-1:0] dev_ready,
  output logic               all_ready
);

  always_comb all_ready = &dev_ready;

endmodule

// File: rtl/pcc_mem_decoder.sv
module pcc_mem_decoder
  import pcc_pkg::*;
#(
  parameter int DENSITY_MB = 8,
  parameter int MAX_PAIRS  = 4,
  parameter int ADDR_HI_W  = 3
) (
  input  logic                   rst,
  input  logic                   byte_en_lo_n,
  input  logic                   byte_en_hi_n,
  input  logic                   rd_n,
  input  logic                   wr_n,
  input  logic                   attr_sel_n,
  input  logic [ADDR_HI_W-1:0]   addr_hi,
  input  logic [2*MAX_PAIRS-1:0] dev_ready,
  output logic [2*MAX_PAIRS-1:0] flash_ce_n,
  output logic                   attr_ce_n,
  output logic                   mem_oe_n,
  output logic                   mem_we_n,
  output logic                   mem_pwr_dn_n,
  output logic                   lane_lo_drv,
  output logic                   lane_hi_drv,
  output logic                   card_ready,
  output logic                   wait_n,
  output logic                   wr_protect,
  output logic                   batt_ok1,
  output logic                   batt_ok2
);

  localparam int NUM_DEV = 2 * MAX_PAIRS;

  logic    flash_lo_act;
  logic    flash_hi_act;
  logic    attr_act;
  access_t acc;
  logic    lane_lo;
  logic    lane_hi;

  pcc_access_decode u_access (
    .rst          (rst),
    .byte_en_lo_n (byte_en_lo_n),
    .byte_en_hi_n (byte_en_hi_n),
    .rd_n         (rd_n),
    .wr_n         (wr_n),
    .attr_sel_n   (attr_sel_n),
    .flash_lo_act (flash_lo_act),
    .flash_hi_act (flash_hi_act),
    .attr_act     (attr_act),
    .acc          (acc),
    .lane_lo      (lane_lo),
    .lane_hi      (lane_hi)
  );

  pcc_pair_select #(
    .DENSITY_MB (DENSITY_MB),
    .MAX_PAIRS  (MAX_PAIRS),
    .ADDR_HI_W  (ADDR_HI_W)
  ) u_pairs (
    .addr_hi (addr_hi),
    .lo_act  (flash_lo_act),
    .hi_act  (flash_hi_act),
    .ce_n    (flash_ce_n)
  );

  pcc_ready_merge #(
    .NUM_DEV (NUM_DEV)
  ) u_ready (
    .dev_ready (dev_ready),
    .all_ready (card_ready)
  );

  always_comb begin
    attr_ce_n    = ~attr_act;
    mem_oe_n     = ~acc.rd;
    mem_we_n     = ~acc.wr;
    mem_pwr_dn_n = ~rst;
    lane_lo_drv  = lane_lo;
    lane_hi_drv  = lane_hi;
    wait_n       = 1'b1;
    wr_protect   = 1'b0;
    batt_ok1     = 1'b1;
    batt_ok2     = 1'b1;
  end

  // Split enables by byte side for the checks below.
  logic [MAX_PAIRS-1:0] even_on;
  logic [MAX_PAIRS-1:0] odd_on;
  for (genvar p = 0; p < MAX_PAIRS; p++) begin : g_side
    always_comb begin
      even_on[p] = ~flash_ce_n[2*p];
      odd_on[p]  = ~flash_ce_n[2*p+1];
    end
  end

  always_comb begin
    if (byte_en_lo_n && byte_en_hi_n)
      p_standby_quiet_r1: assert (&flash_ce_n && attr_ce_n && !lane_lo_drv && !lane_hi_drv)
        else $error("standby left a device or lane active");
    p_one_pair_r2: assert ($onehot0(even_on) && $onehot0(odd_on))
      else $error("more than one pair enabled");
    p_lane_side_r2: assert (!lane_hi_drv || $countones(odd_on) == 1)
      else $error("high lane driven without odd device");
    p_strobe_excl_r3: assert (mem_oe_n || mem_we_n)
      else $error("read and write strobes both active");
    if (!attr_sel_n)
      p_attr_no_flash_r4: assert (&flash_ce_n && !lane_hi_drv)
        else $error("flash or high lane active in attribute space");
    if (card_ready)
      p_ready_all_r7: assert (&dev_ready)
        else $error("ready while a device is busy");
    if (rst)
      p_reset_idle_r9: assert (&flash_ce_n && attr_ce_n && mem_oe_n && mem_we_n && !mem_pwr_dn_n)
        else $error("activity during reset");
  end

endmodule

// File: tb/pcc_mem_decoder_tb.sv
module pcc_mem_decoder_tb;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic       rst, ce1_n, ce2_n, rd_n, wr_n, reg_n;
  logic [2:0] addr;
  logic [7:0] rdy;

  logic [7:0] ce8, ce16, ce2;
  logic       at8, at16, at2;
  logic       oe8, oe16, oe2, we8, we16, we2;
  logic       pd8, pd16, pd2;
  logic       ll8, ll16, ll2, lh8, lh16, lh2;
  logic       ry8, ry16, ry2;
  logic       wt8, wt16, wt2, wp8, wp16, wp2;
  logic       b18, b116, b12, b28, b216, b22;

  pcc_mem_decoder #(.DENSITY_MB(8)) u_dut (
    .rst(rst), .byte_en_lo_n(ce1_n), .byte_en_hi_n(ce2_n), .rd_n(rd_n), .wr_n(wr_n),
    .attr_sel_n(reg_n), .addr_hi(addr), .dev_ready(rdy), .flash_ce_n(ce8), .attr_ce_n(at8),
    .mem_oe_n(oe8), .mem_we_n(we8), .mem_pwr_dn_n(pd8), .lane_lo_drv(ll8), .lane_hi_drv(lh8),
    .card_ready(ry8), .wait_n(wt8), .wr_protect(wp8), .batt_ok1(b18), .batt_ok2(b28));

  pcc_mem_decoder #(.DENSITY_MB(16)) u_dut_d16 (
    .rst(rst), .byte_en_lo_n(ce1_n), .byte_en_hi_n(ce2_n), .rd_n(rd_n), .wr_n(wr_n),
    .attr_sel_n(reg_n), .addr_hi(addr), .dev_ready(rdy), .flash_ce_n(ce16), .attr_ce_n(at16),
    .mem_oe_n(oe16), .mem_we_n(we16), .mem_pwr_dn_n(pd16), .lane_lo_drv(ll16), .lane_hi_drv(lh16),
    .card_ready(ry16), .wait_n(wt16), .wr_protect(wp16), .batt_ok1(b116), .batt_ok2(b216));

  pcc_mem_decoder #(.DENSITY_MB(2)) u_dut_d2 (
    .rst(rst), .byte_en_lo_n(ce1_n), .byte_en_hi_n(ce2_n), .rd_n(rd_n), .wr_n(wr_n),
    .attr_sel_n(reg_n), .addr_hi(addr), .dev_ready(rdy), .flash_ce_n(ce2), .attr_ce_n(at2),
    .mem_oe_n(oe2), .mem_we_n(we2), .mem_pwr_dn_n(pd2), .lane_lo_drv(ll2), .lane_hi_drv(lh2),
    .card_ready(ry2), .wait_n(wt2), .wr_protect(wp2), .batt_ok1(b12), .batt_ok2(b22));

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Reference model of the select decode, built from the requirements.
  function automatic logic [7:0] exp_ce(input int dens, input logic [2:0] a);
    int pairs = (dens == 2) ? 1 : (dens == 4) ? 2 : 4;
    int ofs   = (dens == 16) ? 1 : 0;
    int p     = (int'(a) >> ofs) % pairs;
    logic [7:0] v = 8'hFF;
    if (!rst && reg_n) begin
      v[2*p]   = ce1_n;
      v[2*p+1] = ce2_n;
    end
    return v;
  endfunction

  task automatic check_dut(input int dens, input logic [7:0] ce, input logic at,
                           input logic oe, input logic we, input logic pd,
                           input logic ll, input logic lh);
    logic [7:0] e_ce = exp_ce(dens, addr);
    logic e_at  = !(!rst && !reg_n && !ce1_n);
    logic sel   = (e_ce != 8'hFF) || !e_at;
    logic rd    = !rd_n && wr_n;
    logic wr    = rd_n && !wr_n;
    string tag;
    if (rst)                    tag = "R9 reset";
    else if (ce1_n && ce2_n)    tag = "R1 standby";
    else if (!reg_n)            tag = "R4 attribute";
    else                        tag = "R2/R5 pair select";
    chk($sformatf("%s ce dens=%0d", tag, dens), ce, e_ce);
    chk($sformatf("%s attr ce", tag), at, e_at);
    chk($sformatf("R3 %s read strobe", tag), oe, !(rd && sel));
    chk($sformatf("R3 %s write strobe", tag), we, !(wr && sel));
    chk($sformatf("R2 %s low lane", tag), ll, !rst && rd && !ce1_n);
    chk($sformatf("R2 %s high lane", tag), lh, !rst && rd && !ce2_n && reg_n);
    chk("R9 power down", pd, !rst);
  endtask

  initial begin
    int cyc = 0;
    while (cyc < WATCHDOG && !done) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; ce1_n = 1'b1; ce2_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1;
    reg_n = 1'b1; addr = 3'd0; rdy = 8'hFF;
    @(negedge clk);
    // Reset state (R9).
    chk("R9 reset ce", ce8, 8'hFF);
    chk("R9 reset pwr", pd8, 1'b0);

    // Full control/address sweep on all three densities.
    for (int v = 0; v < 512; v++) begin
      @(posedge clk);
      ce1_n = v[0]; ce2_n = v[1]; rd_n = v[2]; wr_n = v[3]; reg_n = v[4];
      addr  = v[7:5]; rst = v[8];
      @(negedge clk);
      check_dut(8,  ce8,  at8,  oe8,  we8,  pd8,  ll8,  lh8);
      check_dut(16, ce16, at16, oe16, we16, pd16, ll16, lh16);
      check_dut(2,  ce2,  at2,  oe2,  we2,  pd2,  ll2,  lh2);
      chk("R6 unpopulated 2MB", {24'd0, ce2[7:2]}, 32'h3F);
      chk("R8 constants", {wt8, wp8, b18, b28, wt16, wp16, b116, b216},
          {4'b1011, 4'b1011});
    end

    // Directed corner: odd-only read returns nothing on the low lane (R2).
    @(posedge clk);
    rst = 0; reg_n = 1; ce1_n = 1; ce2_n = 0; rd_n = 0; wr_n = 1; addr = 3'b110;
    @(negedge clk);
    chk("R2 odd-only low lane", ll8, 1'b0);
    chk("R5 8MB pair from A22:A21", ce8, 8'hDF);
    chk("R5 16MB pair from A23:A22", ce16, 8'h7F);

    // Ready merge over every pattern (R7).
    for (int b = 0; b < 256; b++) begin
      @(posedge clk);
      rdy = b[7:0];
      @(negedge clk);
      chk("R7 ready merge", {ry8, ry16, ry2}, {3{b == 255}});
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

endmodule